// File: doc/BRIEF.md
# Clustered Vector Issue and Register Location Tracker

This block is the single-issue front of a vector coprocessor built from several small execution clusters. It takes one decoded vector instruction at a time. The instruction carries an operation class, up to two source registers and one destination register, all drawn from a 32-entry architectural register space. The block keeps a location map that says where each architectural register lives at present. A register is either in the shared global register file or in one local slot of one cluster.

For each accepted instruction the block picks the cluster that will run it. It then emits a short sequence of commands on a valid/ready control bus. The sequence can start with a spill, which moves a local value back to the global file to free a slot. Next come transfers that bring non-local sources to the chosen cluster. Last comes the instruction itself, with every operand and the result named by physical location. The block does not move data, execute operations or chain elements: the clusters do that.

Top module: `vdisp_issue`

## Requirements
- R1: After reset `in_ready` is high, `cmd_valid` is low, every architectural register maps to the global file, and every local slot is free.
- R2: Only a cluster whose bit in `SUPPORT` is set for the instruction's class is chosen. Bit index is `cluster*NCLASS + class`.
- R3: Among the supporting clusters the winner has the most sources held locally. Ties are broken first by having a free local slot, then by the lowest busy count, then by the cluster index equal to `in_hint`, and last by the lowest cluster index.
- R4: Each enabled source that is not local to the chosen cluster produces one transfer command (`cmd_kind` 1). It names the register and its current location (`cmd_from_local`, `cmd_from_cluster`, `cmd_slot`). A second source equal to the first produces no second transfer. A local source produces no transfer, and the instruction command marks it local with its slot.
- R5: The result goes to a local slot of the chosen cluster. That slot is the destination's own slot if the destination already lives there, and otherwise the lowest free slot. The map then points at that slot, so later transfers of that register name it as their origin.
- R6: If the chosen cluster has no free slot and does not already hold the destination, a spill command (`cmd_kind` 0) comes first. It names the lowest-index occupied slot that holds neither source. That register then maps to the global file, and the result takes the freed slot.
- R7: Commands go out one per accepted handshake in a fixed order: spill, transfer of source A, transfer of source B, then the instruction (`cmd_kind` 2). The first command is valid in the cycle after the input is accepted. With `cmd_ready` held high the commands follow back to back.
- R8: A command that is not accepted stays valid with unchanged fields. `in_ready` stays low from the accept until the instruction command has been taken.
- R9: When the destination had a local copy in another cluster, that copy's slot becomes free once the instruction command is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted when high together with in_valid |
| in_class | input | KW | Operation class |
| in_src_a | input | AW | Architectural source A |
| in_src_a_en | input | 1 | Source A is used |
| in_src_b | input | AW | Architectural source B |
| in_src_b_en | input | 1 | Source B is used |
| in_dst | input | AW | Architectural destination |
| in_hint | input | CW | Software cluster hint |
| cl_busy | input | NC*BW | Busy count per cluster, cluster c at bits c*BW +: BW |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command taken |
| cmd_kind | output | 2 | 0 spill, 1 transfer, 2 instruction |
| cmd_cluster | output | CW | Cluster the command addresses |
| cmd_areg | output | AW | Spilled register, transferred source, or destination |
| cmd_slot | output | SW | Spilled slot, origin slot of a transfer, or result slot |
| cmd_from_local | output | 1 | Transfer origin is a local slot (0: global file) |
| cmd_from_cluster | output | CW | Cluster holding the transfer origin |
| cmd_class | output | KW | Operation class of the instruction |
| cmd_a_local | output | 1 | Source A read from a local slot |
| cmd_a_slot | output | SW | Local slot of source A |
| cmd_b_local | output | 1 | Source B read from a local slot |
| cmd_b_slot | output | SW | Local slot of source B |

## Verification
A corrupt location map does not show on the ports until a later instruction reads the damaged entry. That instruction gets a missing or extra transfer, a wrong origin, or a wrong operand slot. The directed sequence therefore reuses registers across instructions, so that each update from R5, R6 and R9 is read back by the next instruction within a few cycles. A bad slot-occupancy bit shows up as a spill that should not happen, a missing spill, or a wrong result slot once a cluster fills. A bad phase register shows up at once, as commands in the wrong order or as `in_ready` out of step with the final command.

// File: rtl/vdisp_pkg.sv
package vdisp_pkg;

    typedef enum logic [1:0] {
        CMD_SPILL = 2'd0,
        CMD_XFER  = 2'd1,
        CMD_EXEC  = 2'd2
    } cmd_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SPILL = 3'd1,
        PH_XA    = 3'd2,
        PH_XB    = 3'd3,
        PH_EXEC  = 3'd4
    } phase_e;

endpackage

// File: rtl/vdisp_slot_scan.sv
// Per-cluster slot search: lowest free slot and lowest spillable slot.
module vdisp_slot_scan #(
    parameter int NS = 4,
    localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic [NS-1:0] used_i,
    input  logic [NS-1:0] excl_i,
    output logic          has_free_o,
    output logic [SW-1:0] free_idx_o,
    output logic [SW-1:0] victim_idx_o
);
    always_comb begin
        has_free_o   = 1'b0;
        free_idx_o   = '0;
        victim_idx_o = '0;
        for (int s = NS - 1; s >= 0; s--) begin
            if (!used_i[s]) begin
                has_free_o = 1'b1;
                free_idx_o = SW'(s);
            end
            if (used_i[s] && !excl_i[s]) begin
                victim_idx_o = SW'(s);
            end
        end
    end
endmodule

// File: rtl/vdisp_pick.sv
// Cluster selection by a lexicographic score; lower index wins ties.
module vdisp_pick #(
    parameter int NC = 2,
    parameter int BW = 4,
    localparam int CW = (NC > 1) ? $clog2(NC) : 1,
    localparam int SCW = 2 + 1 + BW + 1
) (
    input  logic [NC-1:0]    supp_i,
    input  logic [NC*2-1:0]  cnt_i,
    input  logic [NC-1:0]    free_i,
    input  logic [NC*BW-1:0] busy_i,
    input  logic [CW-1:0]    hint_i,
    output logic [CW-1:0]    win_o
);
    logic [SCW-1:0] best;
    logic [SCW-1:0] sc;
    logic           found;

    always_comb begin
        best  = '0;
        sc    = '0;
        found = 1'b0;
        win_o = '0;
        for (int c = 0; c < NC; c++) begin
            sc = {cnt_i[c*2 +: 2], free_i[c], ~busy_i[c*BW +: BW],
                  (hint_i == CW'(c))};
            if (supp_i[c] && (!found || sc > best)) begin
                found = 1'b1;
                best  = sc;
                win_o = CW'(c);
            end
        end
    end
endmodule

// File: rtl/vdisp_issue.sv
module vdisp_issue #(
    parameter int NC        = 2,
    parameter int NS        = 4,
    parameter int ARCH_REGS = 32,
    parameter int NCLASS    = 4,
    parameter int BW        = 4,
    parameter logic [NC*NCLASS-1:0] SUPPORT = 8'b1101_1011,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int CW = (NC > 1) ? $clog2(NC) : 1,
    localparam int SW = (NS > 1) ? $clog2(NS) : 1,
    localparam int KW = (NCLASS > 1) ? $clog2(NCLASS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [KW-1:0]    in_class,
    input  logic [AW-1:0]    in_src_a,
    input  logic             in_src_a_en,
    input  logic [AW-1:0]    in_src_b,
    input  logic             in_src_b_en,
    input  logic [AW-1:0]    in_dst,
    input  logic [CW-1:0]    in_hint,
    input  logic [NC*BW-1:0] cl_busy,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [1:0]       cmd_kind,
    output logic [CW-1:0]    cmd_cluster,
    output logic [AW-1:0]    cmd_areg,
    output logic [SW-1:0]    cmd_slot,
    output logic             cmd_from_local,
    output logic [CW-1:0]    cmd_from_cluster,
    output logic [KW-1:0]    cmd_class,
    output logic             cmd_a_local,
    output logic [SW-1:0]    cmd_a_slot,
    output logic             cmd_b_local,
    output logic [SW-1:0]    cmd_b_slot
);
    import vdisp_pkg::*;

    typedef struct packed {
        logic          loc;
        logic [CW-1:0] cl;
        logic [SW-1:0] slot;
    } where_t;

    typedef struct packed {
        logic          used;
        logic [AW-1:0] areg;
    } slot_t;

    typedef struct packed {
        phase_e                        ph;
        where_t [ARCH_REGS-1:0]        map;
        slot_t  [NC-1:0][NS-1:0]       tab;
        logic   [KW-1:0]               cls;
        logic   [AW-1:0]               a;
        logic   [AW-1:0]               b;
        logic   [AW-1:0]               dst;
        logic   [CW-1:0]               cl;
        logic                          need_sp;
        logic                          need_xa;
        logic                          need_xb;
        logic   [SW-1:0]               vic_slot;
        logic   [SW-1:0]               dst_slot;
        logic                          a_loc;
        logic   [SW-1:0]               a_slot;
        logic                          b_loc;
        logic   [SW-1:0]               b_slot;
    } st_t;

    st_t s_q, s_d;

    // per-cluster view of the offered instruction
    logic [NC-1:0]    a_here, b_here, dst_here, supp, has_free;
    logic [NC*2-1:0]  cnt;
    logic [SW-1:0]    free_idx [NC];
    logic [SW-1:0]    vic_idx  [NC];
    logic [CW-1:0]    win;
    logic             fire;
    where_t           loc_a, loc_b, loc_dst, old_dst;
    logic             dup_b;

    assign loc_a   = s_q.map[in_src_a];
    assign loc_b   = s_q.map[in_src_b];
    assign loc_dst = s_q.map[in_dst];
    assign old_dst = s_q.map[s_q.dst];
    assign dup_b   = in_src_a_en && (in_src_b == in_src_a);

    for (genvar c = 0; c < NC; c++) begin : g_cl
        logic [NS-1:0] used_v, excl_v;
        always_comb begin
            for (int s = 0; s < NS; s++) begin
                used_v[s] = s_q.tab[c][s].used;
                excl_v[s] = s_q.tab[c][s].used &&
                    ((in_src_a_en && s_q.tab[c][s].areg == in_src_a) ||
                     (in_src_b_en && s_q.tab[c][s].areg == in_src_b));
            end
        end
        assign a_here[c]   = in_src_a_en && loc_a.loc && (loc_a.cl == CW'(c));
        assign b_here[c]   = in_src_b_en && loc_b.loc && (loc_b.cl == CW'(c));
        assign dst_here[c] = loc_dst.loc && (loc_dst.cl == CW'(c));
        assign supp[c]     = SUPPORT[c*NCLASS + int'(in_class)];
        assign cnt[c*2 +: 2] = {1'b0, a_here[c]} + {1'b0, b_here[c]};

        vdisp_slot_scan #(.NS(NS)) u_scan (
            .used_i      (used_v),
            .excl_i      (excl_v),
            .has_free_o  (has_free[c]),
            .free_idx_o  (free_idx[c]),
            .victim_idx_o(vic_idx[c])
        );
    end

    vdisp_pick #(.NC(NC), .BW(BW)) u_pick (
        .supp_i (supp),
        .cnt_i  (cnt),
        .free_i (has_free),
        .busy_i (cl_busy),
        .hint_i (in_hint),
        .win_o  (win)
    );

    assign fire = cmd_valid && cmd_ready;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (in_valid) begin
                    s_d.cls      = in_class;
                    s_d.a        = in_src_a;
                    s_d.b        = in_src_b;
                    s_d.dst      = in_dst;
                    s_d.cl       = win;
                    s_d.need_sp  = !has_free[win] && !dst_here[win];
                    s_d.need_xa  = in_src_a_en && !a_here[win];
                    s_d.need_xb  = in_src_b_en && !b_here[win] && !dup_b;
                    s_d.vic_slot = vic_idx[win];
                    s_d.a_loc    = a_here[win];
                    s_d.a_slot   = a_here[win] ? loc_a.slot : '0;
                    s_d.b_loc    = b_here[win];
                    s_d.b_slot   = b_here[win] ? loc_b.slot : '0;
                    if (dst_here[win])
                        s_d.dst_slot = loc_dst.slot;
                    else if (!has_free[win])
                        s_d.dst_slot = vic_idx[win];
                    else
                        s_d.dst_slot = free_idx[win];
                    if (s_d.need_sp)      s_d.ph = PH_SPILL;
                    else if (s_d.need_xa) s_d.ph = PH_XA;
                    else if (s_d.need_xb) s_d.ph = PH_XB;
                    else                  s_d.ph = PH_EXEC;
                end
            end
            PH_SPILL: begin
                if (fire) begin
                    s_d.tab[s_q.cl][s_q.vic_slot].used = 1'b0;
                    s_d.map[s_q.tab[s_q.cl][s_q.vic_slot].areg] = '0;
                    if (s_q.need_xa)      s_d.ph = PH_XA;
                    else if (s_q.need_xb) s_d.ph = PH_XB;
                    else                  s_d.ph = PH_EXEC;
                end
            end
            PH_XA: begin
                if (fire) s_d.ph = s_q.need_xb ? PH_XB : PH_EXEC;
            end
            PH_XB: begin
                if (fire) s_d.ph = PH_EXEC;
            end
            PH_EXEC: begin
                if (fire) begin
                    if (old_dst.loc && !(old_dst.cl == s_q.cl &&
                                         old_dst.slot == s_q.dst_slot))
                        s_d.tab[old_dst.cl][old_dst.slot].used = 1'b0;
                    s_d.tab[s_q.cl][s_q.dst_slot].used = 1'b1;
                    s_d.tab[s_q.cl][s_q.dst_slot].areg = s_q.dst;
                    s_d.map[s_q.dst].loc  = 1'b1;
                    s_d.map[s_q.dst].cl   = s_q.cl;
                    s_d.map[s_q.dst].slot = s_q.dst_slot;
                    s_d.ph = PH_IDLE;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // command bus
    always_comb begin
        in_ready         = (s_q.ph == PH_IDLE);
        cmd_valid        = (s_q.ph != PH_IDLE);
        cmd_cluster      = s_q.cl;
        cmd_class        = s_q.cls;
        cmd_a_local      = s_q.a_loc;
        cmd_a_slot       = s_q.a_slot;
        cmd_b_local      = s_q.b_loc;
        cmd_b_slot       = s_q.b_slot;
        cmd_kind         = CMD_EXEC;
        cmd_areg         = s_q.dst;
        cmd_slot         = s_q.dst_slot;
        cmd_from_local   = 1'b0;
        cmd_from_cluster = '0;
        unique case (s_q.ph)
            PH_SPILL: begin
                cmd_kind = CMD_SPILL;
                cmd_areg = s_q.tab[s_q.cl][s_q.vic_slot].areg;
                cmd_slot = s_q.vic_slot;
            end
            PH_XA: begin
                cmd_kind         = CMD_XFER;
                cmd_areg         = s_q.a;
                cmd_slot         = s_q.map[s_q.a].slot;
                cmd_from_local   = s_q.map[s_q.a].loc;
                cmd_from_cluster = s_q.map[s_q.a].cl;
            end
            PH_XB: begin
                cmd_kind         = CMD_XFER;
                cmd_areg         = s_q.b;
                cmd_slot         = s_q.map[s_q.b].slot;
                cmd_from_local   = s_q.map[s_q.b].loc;
                cmd_from_cluster = s_q.map[s_q.b].cl;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vdisp_issue_chk.sv
module vdisp_issue_chk #(
    parameter int NC     = 2,
    parameter int NCLASS = 4,
    parameter logic [NC*NCLASS-1:0] SUPPORT = 8'b1101_1011,
    parameter int CW = 1,
    parameter int AW = 5,
    parameter int SW = 2,
    parameter int KW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [1:0]    cmd_kind,
    input logic [CW-1:0] cmd_cluster,
    input logic [AW-1:0] cmd_areg,
    input logic [SW-1:0] cmd_slot,
    input logic [KW-1:0] cmd_class
);
    logic          fire;
    logic          sp_seen;
    logic [SW-1:0] sp_slot;
    logic [CW-1:0] sp_cl;

    assign fire = cmd_valid && cmd_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_seen <= 1'b0;
            sp_slot <= '0;
            sp_cl   <= '0;
        end else if (fire && cmd_kind == 2'd0) begin
            sp_seen <= 1'b1;
            sp_slot <= cmd_slot;
            sp_cl   <= cmd_cluster;
        end else if (fire && cmd_kind == 2'd2) begin
            sp_seen <= 1'b0;
        end
    end

    a_r2_supported: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == 2'd2 |-> SUPPORT[int'(cmd_cluster)*NCLASS + int'(cmd_class)]);

    a_r6_spill_slot_reused: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cmd_kind == 2'd2 && sp_seen |-> cmd_slot == sp_slot && cmd_cluster == sp_cl);

    a_r7_first_cmd_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> cmd_valid);

    a_r7_no_late_spill: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cmd_kind != 2'd2 |=> cmd_valid && cmd_kind != 2'd0);

    a_r7_exec_ends: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cmd_kind == 2'd2 |=> in_ready && !cmd_valid);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) &&
            $stable(cmd_cluster) && $stable(cmd_areg) && $stable(cmd_slot));
endmodule

bind vdisp_issue vdisp_issue_chk #(
    .NC(NC), .NCLASS(NCLASS), .SUPPORT(SUPPORT),
    .CW(CW), .AW(AW), .SW(SW), .KW(KW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_kind   (cmd_kind),
    .cmd_cluster(cmd_cluster),
    .cmd_areg   (cmd_areg),
    .cmd_slot   (cmd_slot),
    .cmd_class  (cmd_class)
);

// File: tb/test_vdisp_issue.sv
`timescale 1ns/1ps
module test_vdisp_issue;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_class = '0;
    logic [4:0] in_src_a = '0;
    logic       in_src_a_en = 1'b0;
    logic [4:0] in_src_b = '0;
    logic       in_src_b_en = 1'b0;
    logic [4:0] in_dst = '0;
    logic       in_hint = 1'b0;
    logic [7:0] cl_busy = '0;
    logic       cmd_valid;
    logic       cmd_ready = 1'b1;
    logic [1:0] cmd_kind;
    logic       cmd_cluster;
    logic [4:0] cmd_areg;
    logic [1:0] cmd_slot;
    logic       cmd_from_local;
    logic       cmd_from_cluster;
    logic [1:0] cmd_class;
    logic       cmd_a_local;
    logic [1:0] cmd_a_slot;
    logic       cmd_b_local;
    logic [1:0] cmd_b_slot;

    int n_chk = 0;
    int n_bad = 0;
    int n_rec;
    int rk[8], rc[8], ra[8], rs[8], rfl[8], rfc[8], ral[8], ras[8], rbl[8], rbs[8];

    always #2.5 clk = ~clk;

    vdisp_issue i_vdisp_issue (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_class(in_class), .in_src_a(in_src_a), .in_src_a_en(in_src_a_en),
        .in_src_b(in_src_b), .in_src_b_en(in_src_b_en), .in_dst(in_dst),
        .in_hint(in_hint), .cl_busy(cl_busy), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_cluster(cmd_cluster),
        .cmd_areg(cmd_areg), .cmd_slot(cmd_slot), .cmd_from_local(cmd_from_local),
        .cmd_from_cluster(cmd_from_cluster), .cmd_class(cmd_class),
        .cmd_a_local(cmd_a_local), .cmd_a_slot(cmd_a_slot),
        .cmd_b_local(cmd_b_local), .cmd_b_slot(cmd_b_slot)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Offer one instruction and record the command sequence up to the instruction command.
    task automatic run(input int cls, input int a, input int ae, input int b, input int be,
                       input int d, input int hint, input int busy0, input int busy1,
                       input bit bp);
        bit done = 0;
        bit stalled = 0;
        int pk = 0, pc = 0, pa = 0, ps = 0;
        @(negedge clk);
        in_class = 2'(cls); in_src_a = 5'(a); in_src_a_en = ae[0];
        in_src_b = 5'(b); in_src_b_en = be[0]; in_dst = 5'(d);
        in_hint = hint[0]; cl_busy = {4'(busy1), 4'(busy0)}; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        n_rec = 0;
        for (int cyc = 0; cyc < 64 && !done; cyc++) begin
            if (bp) begin
                cmd_ready = (cyc % 2) == 1;
                // R8: stalled command held with unchanged fields, input held off
                if (stalled)
                    chk(cmd_valid && cmd_kind == 2'(pk) && cmd_cluster == pc[0] &&
                        cmd_areg == 5'(pa) && cmd_slot == 2'(ps), "R8", "held command kind",
                        int'(cmd_kind), pk);
                chk(!(cmd_valid && in_ready), "R8", "in_ready while busy", int'(in_ready), 0);
            end
            if (cmd_valid && cmd_ready && n_rec < 8) begin
                rk[n_rec] = cmd_kind; rc[n_rec] = cmd_cluster; ra[n_rec] = cmd_areg;
                rs[n_rec] = cmd_slot; rfl[n_rec] = cmd_from_local;
                rfc[n_rec] = cmd_from_cluster; ral[n_rec] = cmd_a_local;
                ras[n_rec] = cmd_a_slot; rbl[n_rec] = cmd_b_local; rbs[n_rec] = cmd_b_slot;
                if (cmd_kind == 2'd2) done = 1;
                n_rec++;
            end
            stalled = cmd_valid && !cmd_ready;
            pk = cmd_kind; pc = cmd_cluster; pa = cmd_areg; ps = cmd_slot;
            @(negedge clk);
        end
        cmd_ready = 1'b1;
        chk(done && in_ready, "R7", "sequence ended with instruction", int'(done), 1);
    endtask

    task automatic cmd_is(input int i, input int k, input int cl, input int ar,
                          input int sl, input string req);
        chk(rk[i] == k && rc[i] == cl && ra[i] == ar && rs[i] == sl, req,
            $sformatf("cmd %0d {kind,cl,areg,slot}={%0d,%0d,%0d,%0d}", i, rk[i], rc[i], ra[i], rs[i]),
            (rk[i] << 12) | (rc[i] << 10) | (ra[i] << 4) | rs[i],
            (k << 12) | (cl << 10) | (ar << 4) | sl);
    endtask

    task automatic from_is(input int i, input int fl, input int fc, input string req);
        chk(rfl[i] == fl && rfc[i] == fc, req, $sformatf("cmd %0d origin {local,cl}", i),
            rfl[i] * 2 + rfc[i], fl * 2 + fc);
    endtask

    task automatic ops_is(input int i, input int al, input int as, input int bl,
                          input int bs, input string req);
        chk(ral[i] == al && ras[i] == as && rbl[i] == bl && rbs[i] == bs, req,
            $sformatf("cmd %0d operands {al,as,bl,bs}", i),
            ral[i] * 1000 + ras[i] * 100 + rbl[i] * 10 + rbs[i],
            al * 1000 + as * 100 + bl * 10 + bs);
    endtask

    task automatic count_is(input int n, input string req);
        chk(n_rec == n, req, "command count", n_rec, n);
    endtask

    task automatic t_reset;
        chk(in_ready && !cmd_valid, "R1", "idle after reset", int'(cmd_valid), 0);
    endtask

    task automatic t_two_global_sources;   // R1 R4 R5 R7
        run(0, 1, 1, 2, 1, 3, 0, 0, 0, 0);
        count_is(3, "R7");
        cmd_is(0, 1, 0, 1, 0, "R4"); from_is(0, 0, 0, "R1");
        cmd_is(1, 1, 0, 2, 0, "R4"); from_is(1, 0, 0, "R1");
        cmd_is(2, 2, 0, 3, 0, "R5"); ops_is(2, 0, 0, 0, 0, "R4");
    endtask

    task automatic t_class_only_one;       // R2: class 2 runs only on cluster 1
        run(2, 3, 1, 0, 0, 4, 0, 0, 0, 0);
        count_is(2, "R2");
        cmd_is(0, 1, 1, 3, 0, "R2"); from_is(0, 1, 0, "R5");
        cmd_is(1, 2, 1, 4, 0, "R2");
    endtask

    task automatic t_locality_beats_hint;  // R3
        run(0, 3, 1, 0, 0, 5, 1, 0, 0, 0);
        count_is(1, "R4");
        cmd_is(0, 2, 0, 5, 1, "R3"); ops_is(0, 1, 0, 0, 0, "R4");
    endtask

    task automatic t_busy_decides;         // R3
        run(0, 10, 1, 11, 1, 6, 0, 5, 2, 0);
        count_is(3, "R3");
        cmd_is(0, 1, 1, 10, 0, "R3");
        cmd_is(1, 1, 1, 11, 0, "R3");
        cmd_is(2, 2, 1, 6, 1, "R3");
    endtask

    task automatic t_hint_decides;         // R3
        run(3, 12, 1, 0, 0, 7, 1, 0, 0, 0);
        count_is(2, "R3");
        cmd_is(1, 2, 1, 7, 2, "R3");
    endtask

    task automatic t_fill_cluster0;        // R5: lowest free slots
        run(1, 0, 1, 0, 0, 8, 0, 0, 0, 0);
        cmd_is(1, 2, 0, 8, 2, "R5");
        run(1, 0, 0, 0, 0, 9, 0, 0, 0, 0);
        count_is(1, "R5");
        cmd_is(0, 2, 0, 9, 3, "R5");
    endtask

    task automatic t_spill;                // R6
        run(1, 3, 1, 8, 1, 13, 0, 0, 0, 0);
        count_is(2, "R6");
        cmd_is(0, 0, 0, 5, 1, "R6");
        cmd_is(1, 2, 0, 13, 1, "R6"); ops_is(1, 1, 0, 1, 2, "R4");
        // spilled register is global again; full cluster reuses the destination's own slot
        run(1, 5, 1, 0, 0, 9, 0, 0, 0, 0);
        count_is(2, "R5");
        cmd_is(0, 1, 0, 5, 0, "R6"); from_is(0, 0, 0, "R6");
        cmd_is(1, 2, 0, 9, 3, "R5");
    endtask

    task automatic t_dst_moves;            // R9
        run(2, 0, 0, 0, 0, 3, 0, 0, 0, 0);
        cmd_is(0, 2, 1, 3, 3, "R9");
        run(1, 3, 1, 0, 0, 14, 0, 0, 0, 0);
        count_is(2, "R9");
        cmd_is(0, 1, 0, 3, 3, "R9"); from_is(0, 1, 1, "R9");
        cmd_is(1, 2, 0, 14, 0, "R9");
    endtask

    task automatic t_backpressure;         // R7 R8 with spill and two transfers
        run(0, 20, 1, 21, 1, 22, 0, 0, 0, 1);
        count_is(4, "R7");
        cmd_is(0, 0, 0, 14, 0, "R6");
        cmd_is(1, 1, 0, 20, 0, "R7");
        cmd_is(2, 1, 0, 21, 0, "R7");
        cmd_is(3, 2, 0, 22, 0, "R7");
    endtask

    task automatic t_same_source;          // R4 duplicate sources
        run(3, 22, 1, 22, 1, 22, 1, 0, 0, 0);
        count_is(1, "R4");
        cmd_is(0, 2, 0, 22, 0, "R5"); ops_is(0, 1, 0, 1, 0, "R4");
        run(2, 22, 1, 22, 1, 15, 0, 0, 0, 0);
        count_is(3, "R4");
        cmd_is(0, 0, 1, 4, 0, "R6");
        cmd_is(1, 1, 1, 22, 0, "R4"); from_is(1, 1, 0, "R4");
        cmd_is(2, 2, 1, 15, 0, "R6");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_two_global_sources;
        t_class_only_one;
        t_locality_beats_hint;
        t_busy_decides;
        t_hint_decides;
        t_fill_cluster0;
        t_spill;
        t_dst_moves;
        t_backpressure;
        t_same_source;
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule